// File: doc/BRIEF.md
# Byte-wide program bootstrap loader

This block runs straight out of reset and fills internal 24-bit program RAM before the core is allowed to run. Its first step is a slow read of the boot window base address on the external program bus. The top bit of the data bus in that read picks the load source. When the bit is high, the program is copied from an 8-bit boot ROM. When it is low, the bytes come from a host port through a valid/ready byte handshake.

Either way, three bytes build one instruction word, least significant byte first. Each finished word is written into program RAM at the next word address, starting at zero. Every ROM access holds the read strobe and the address for a fixed number of wait states. Only the low data lane is used.

While the load runs, the block reports the loading memory map: program reads go to external memory and program writes go to internal RAM. After the last word is written, the map switches to run mode, in which internal RAM serves both reads and writes. The core-run signal is then released so that execution starts at address zero, and a one-cycle done pulse marks the change.

Top module: `pram_boot_seq`

## Requirements
- R1: While reset is low, the block shows: map_mode = 1, core_run = 0, boot_done = 0, pram_we = 0, host_ready = 0, ext_rd = 1 and ext_addr = 0xC000. The first access starts at the base address.
- R2: The first access reads 0xC000. Bit 23 of ext_data, sampled in the last cycle of that access, selects the source: 1 selects the byte ROM, 0 selects the host port. With the host port selected, host_ready is first high 16 cycles after reset release.
- R3: Every ROM access keeps ext_rd high and ext_addr unchanged for exactly WAIT_STATES+1 = 16 consecutive cycles. Data is taken in the last of those cycles.
- R4: ROM bytes are fetched at 0xC000+k for k = 0 to 1535, each address once, in increasing order. The selector read also supplies byte 0.
- R5: Word w is {byte 3w+2, byte 3w+1, byte 3w}, so the first byte lands in bits 7:0. Each ROM byte is taken from ext_data[7:0], and ext_data[22:8] has no effect on the loaded data.
- R6: Each word is written with a single-cycle pram_we pulse at pram_addr = w, for w = 0 to 511 in order. The pulse comes in the cycle right after the word's third byte is taken.
- R7: In host mode, a byte is taken only in a cycle where both host_valid and host_ready are high, and the same byte order applies. host_ready is low during write cycles, and ext_rd stays low for the whole host load.
- R8: map_mode is 1 up to and including the cycle of the last write. From the next cycle on it is 2, and it stays 2.
- R9: core_run stays 0 until the last word is written and is 1 from the next cycle on. boot_done is high in exactly that one cycle.
- R10: Once core_run is high, ext_rd, pram_we and host_ready stay low whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | output | 16 | External program address during a ROM read |
| ext_rd | output | 1 | External program read strobe, held for the whole slow access |
| ext_data | input | 24 | External data bus: bit 23 is the selector, bits 7:0 carry ROM bytes |
| host_valid | input | 1 | Host byte valid |
| host_byte | input | 8 | Host byte |
| host_ready | output | 1 | Loader can take a host byte this cycle |
| pram_we | output | 1 | Internal program RAM write enable |
| pram_addr | output | 9 | Internal program RAM word address |
| pram_wdata | output | 24 | Assembled instruction word |
| map_mode | output | 2 | Memory map: 1 = reads external, writes internal; 2 = internal for both |
| core_run | output | 1 | Core released to execute from address zero |
| boot_done | output | 1 | One-cycle pulse when loading completes |

## Verification
- **ROM timing.** Each ROM address must hold for 16 sampled cycles. The bench measures every run of constant ext_addr under ext_rd and flags any run of another length.
- **Write timing.** A write must appear in the sample right after the last cycle of the word's third-byte access (ROM). On the host path, it must appear in the sample right after the third byte's handshake edge. The bench keeps the previous sample's read state and transfer count and compares each write against them.
- **Host selection.** host_ready must first show 16 cycles after reset release. The bench counts falling edges from the release edge.
- **Completion.** boot_done, core_run and map_mode are checked in the sample that follows the last write, and for a stretch of cycles afterwards.
- **Sampling.** All outputs are sampled on the falling edge, and inputs change there too.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_SEL,
    ST_ROM,
    ST_HOST,
    ST_WRITE,
    ST_DONE,
    ST_RUN
  } boot_state_t;

  typedef enum logic {
    SRC_ROM,
    SRC_HOST
  } boot_src_t;

  localparam logic [1:0] MAP_LOAD = 2'd1;
  localparam logic [1:0] MAP_RUN  = 2'd2;

endpackage

// File: rtl/slow_access_timer.sv
module slow_access_timer #(
  parameter int WAIT_STATES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic last
);

  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAIT_STATES);

  logic [CNT_W-1:0] cnt, cnt_d;

  assign last = active && (cnt == CNT_END);

  always_comb begin
    cnt_d = cnt;
    if (!active || last) cnt_d = '0;
    else                 cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: the wait counter never runs past the programmed wait-state count
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_END);

  // R3: an access that has not reached its end keeps counting
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
  parameter int LANES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [7:0]         byte_in,
  output logic               at_last,
  output logic [LANES*8-1:0] word
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LANE_END = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane, lane_d;

  assign at_last = (lane == LANE_END);

  always_comb begin
    lane_d = lane;
    if (take) lane_d = at_last ? '0 : lane + LANE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane <= '0;
    else        lane <= lane_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = take && (lane == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word[g*8 +: 8] <= '0;
      else if (lane_en) word[g*8 +: 8] <= byte_in;
    end
  end

  // R5: the lane pointer stays inside the word
  p_lane_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lane <= LANE_END);

  // R5: with no byte offered the pointer holds its position
  p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(lane));

endmodule

// File: rtl/pram_boot_seq.sv
module pram_boot_seq
  import boot_pkg::*;
#(
  parameter int              NWORDS      = 512,
  parameter int              WAIT_STATES = 15,
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hC000,
  localparam int             WADDR_W     = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               ext_rd,
  input  logic [DATA_W-1:0]  ext_data,
  input  logic               host_valid,
  input  logic [7:0]         host_byte,
  output logic               host_ready,
  output logic               pram_we,
  output logic [WADDR_W-1:0] pram_addr,
  output logic [DATA_W-1:0]  pram_wdata,
  output logic [1:0]         map_mode,
  output logic               core_run,
  output logic               boot_done
);

  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int NBYTES         = NWORDS * BYTES_PER_WORD;
  localparam int BIDX_W         = $clog2(NBYTES + 1);
  localparam int SEL_BIT        = DATA_W - 1;
  localparam logic [WADDR_W-1:0] LAST_WORD = WADDR_W'(NWORDS - 1);

  boot_state_t         state, state_d;
  boot_src_t           src, src_d;
  logic [BIDX_W-1:0]   byte_idx, byte_idx_d;
  logic [WADDR_W-1:0]  word_idx, word_idx_d;
  logic                acc_active, acc_last;
  logic                take;
  logic [7:0]          take_byte;
  logic                lane_last;
  logic [DATA_W-1:0]   packed_word;
  logic                unused_hi_bits;

  assign unused_hi_bits = ^ext_data[SEL_BIT-1:8];

  assign acc_active = (state == ST_SEL) || (state == ST_ROM);

  slow_access_timer #(
    .WAIT_STATES (WAIT_STATES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (acc_active),
    .last   (acc_last)
  );

  byte_packer #(
    .LANES (BYTES_PER_WORD)
  ) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (take_byte),
    .at_last (lane_last),
    .word    (packed_word)
  );

  always_comb begin
    state_d    = state;
    src_d      = src;
    byte_idx_d = byte_idx;
    word_idx_d = word_idx;
    take       = 1'b0;
    take_byte  = ext_data[7:0];
    case (state)
      ST_SEL: begin
        if (acc_last) begin
          if (ext_data[SEL_BIT]) begin
            src_d      = SRC_ROM;
            take       = 1'b1;
            byte_idx_d = BIDX_W'(1);
            state_d    = ST_ROM;
          end else begin
            src_d   = SRC_HOST;
            state_d = ST_HOST;
          end
        end
      end
      ST_ROM: begin
        if (acc_last) begin
          take       = 1'b1;
          byte_idx_d = byte_idx + BIDX_W'(1);
          if (lane_last) state_d = ST_WRITE;
        end
      end
      ST_HOST: begin
        take_byte = host_byte;
        if (host_valid) begin
          take = 1'b1;
          if (lane_last) state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (word_idx == LAST_WORD) begin
          state_d = ST_DONE;
        end else begin
          word_idx_d = word_idx + WADDR_W'(1);
          state_d    = (src == SRC_ROM) ? ST_ROM : ST_HOST;
        end
      end
      ST_DONE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEL;
      src      <= SRC_ROM;
      byte_idx <= '0;
      word_idx <= '0;
    end else begin
      state    <= state_d;
      src      <= src_d;
      byte_idx <= byte_idx_d;
      word_idx <= word_idx_d;
    end
  end

  assign ext_rd     = acc_active;
  assign ext_addr   = ROM_BASE + ADDR_W'(byte_idx);
  assign host_ready = (state == ST_HOST);
  assign pram_we    = (state == ST_WRITE);
  assign pram_addr  = word_idx;
  assign pram_wdata = packed_word;
  assign core_run   = (state == ST_DONE) || (state == ST_RUN);
  assign map_mode   = core_run ? MAP_RUN : MAP_LOAD;
  assign boot_done  = (state == ST_DONE);

  // R3: an unfinished access keeps the strobe and the address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && !acc_last) |=> (ext_rd && $stable(ext_addr)));

  // R6: a write pulse lasts one cycle
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we |=> !pram_we);

  // R7: the host handshake and the ROM strobe never overlap
  p_host_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !ext_rd);

  // R8: the run map, once entered, is kept
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == MAP_RUN) |=> (map_mode == MAP_RUN));

  // R9: release follows a write, the done pulse is single, release is sticky
  p_run_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(pram_we));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> (!boot_done && core_run));
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);

  // R10: a running core sees no loader traffic
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> !(ext_rd || pram_we || host_ready));

endmodule

// File: tb/pram_boot_seq_tb.sv
`timescale 1ns/100ps
module pram_boot_seq_tb;

  localparam int NW   = 512;
  localparam int NB   = NW * 3;
  localparam int BASE = 32'hC000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_addr;
  logic        ext_rd;
  logic [23:0] ext_data;
  logic        host_valid = 1'b0;
  logic [7:0]  host_byte = 8'h00;
  logic        host_ready;
  logic        pram_we;
  logic [8:0]  pram_addr;
  logic [23:0] pram_wdata;
  logic [1:0]  map_mode;
  logic        core_run;
  logic        boot_done;
  logic        sel_hi = 1'b1;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int k);
    return 8'((k * 29) + (k >> 4) + 90);
  endfunction

  function automatic logic [7:0] host_b(input int k);
    return 8'((k * 53) ^ (k >> 2) ^ 8'h3C);
  endfunction

  function automatic logic [23:0] word_of(input bit host, input int w);
    if (host) return {host_b(3*w+2), host_b(3*w+1), host_b(3*w)};
    return {rom_byte(3*w+2), rom_byte(3*w+1), rom_byte(3*w)};
  endfunction

  // ROM model: selector on bit 23, junk on the unused lanes, byte on 7:0
  assign ext_data = {sel_hi, ext_addr[14:0] ^ 15'h2A5A, rom_byte(int'(ext_addr) - BASE)};

  pram_boot_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_addr   (ext_addr),
    .ext_rd     (ext_rd),
    .ext_data   (ext_data),
    .host_valid (host_valid),
    .host_byte  (host_byte),
    .host_ready (host_ready),
    .pram_we    (pram_we),
    .pram_addr  (pram_addr),
    .pram_wdata (pram_wdata),
    .map_mode   (map_mode),
    .core_run   (core_run),
    .boot_done  (boot_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_reset_outputs(input string tag);
    check(map_mode == 2'd1, {"R1 map_mode ", tag}, map_mode, 1);
    check(!core_run && !boot_done, {"R1 run/done ", tag}, {core_run, boot_done}, 0);
    check(!pram_we && !host_ready, {"R1 we/ready ", tag}, {pram_we, host_ready}, 0);
    check(ext_rd && ext_addr == 16'hC000, {"R1 first access ", tag}, ext_addr, BASE);
  endtask

  // holds reset, checks R1, releases on a falling edge
  task automatic do_reset(input bit sel);
    @(negedge clk);
    rst_n      = 1'b0;
    sel_hi     = sel;
    host_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_outputs("in reset");
    rst_n = 1'b1;
  endtask

  // R9, R8 and R10 at and after the done sample
  task automatic check_finish(input bit prev_we, input string tag);
    int extra_done = 0;
    int traffic    = 0;
    int not_run    = 0;
    check(prev_we, {"R9 done follows last write ", tag}, prev_we, 1);
    check(core_run && map_mode == 2'd2, {"R8 run map at done ", tag}, map_mode, 2);
    for (int i = 0; i < 40; i++) begin
      host_valid = 1'b1;
      host_byte  = 8'(i);
      sel_hi     = i[0];
      @(negedge clk);
      if (boot_done) extra_done++;
      if (ext_rd || pram_we || host_ready) traffic++;
      if (!core_run || map_mode != 2'd2) not_run++;
    end
    host_valid = 1'b0;
    check(extra_done == 0, {"R9 done lasts one cycle ", tag}, extra_done, 0);
    check(not_run == 0, {"R8 run map kept ", tag}, not_run, 0);
    check(traffic == 0, {"R10 no traffic after release ", tag}, traffic, 0);
  endtask

  task automatic t_rom_boot();
    int  run_addr = 0, run_len = 0, exp_addr = BASE;
    int  bad_len = 0, bad_seq = 0, bad_wr = 0, bad_wtime = 0, mode_bad = 0, host_bad = 0;
    int  wr_cnt = 0, prev_addr = 0;
    bit  prev_rd = 0, prev_we = 0, seen_done = 0;
    do_reset(1'b1);
    for (int n = 0; n < 30000; n++) begin
      if (boot_done) begin
        seen_done = 1;
        break;
      end
      if (ext_rd && prev_rd && int'(ext_addr) == run_addr) begin
        run_len++;
      end else begin
        if (run_len > 0 && run_len != 16) bad_len++;
        run_len = 0;
        if (ext_rd) begin
          if (int'(ext_addr) != exp_addr) bad_seq++;
          exp_addr = int'(ext_addr) + 1;
          run_addr = int'(ext_addr);
          run_len  = 1;
        end
      end
      if (pram_we) begin
        if (int'(pram_addr) != wr_cnt || pram_wdata != word_of(1'b0, wr_cnt)) begin
          bad_wr++;
          if (bad_wr == 1)
            $display("FAIL R5 word %0d actual=%0h expected=%0h",
                     wr_cnt, pram_wdata, word_of(1'b0, wr_cnt));
        end
        if (!(prev_rd && prev_addr == BASE + 3*wr_cnt + 2)) bad_wtime++;
        wr_cnt++;
      end
      if (map_mode != 2'd1 || core_run) mode_bad++;
      if (host_ready) host_bad++;
      prev_rd   = ext_rd;
      prev_we   = pram_we;
      prev_addr = int'(ext_addr);
      @(negedge clk);
    end
    check(seen_done, "R9 ROM boot completes", seen_done, 1);
    check(bad_len == 0, "R3 every ROM access lasts 16 cycles", bad_len, 0);
    check(bad_seq == 0 && exp_addr == BASE + NB, "R4 ROM address order", exp_addr, BASE + NB);
    check(bad_wr == 0, "R5 ROM words little-end first, upper lanes ignored", bad_wr, 0);
    check(bad_wtime == 0 && wr_cnt == NW, "R6 ROM write count and timing", wr_cnt, NW);
    check(mode_bad == 0, "R8 load map held during ROM load", mode_bad, 0);
    check(host_bad == 0, "R2 host port idle in ROM mode", host_bad, 0);
    check_finish(prev_we, "rom");
  endtask

  task automatic t_host_boot(input bit stalls);
    int  first_ready = -1, rd_low_early = 0;
    int  k = 0, wr_cnt = 0, bad_wr = 0, bad_wtime = 0, rd_bad = 0, mode_bad = 0;
    bit  prev_we = 0, seen_done = 0, v;
    do_reset(1'b0);
    for (int i = 0; i <= 40; i++) begin
      if (host_ready) begin
        first_ready = i;
        break;
      end
      if (!ext_rd) rd_low_early++;
      @(negedge clk);
    end
    check(first_ready == 16, "R2 host selected 16 cycles after release", first_ready, 16);
    check(rd_low_early == 0, "R3 selector access strobe held", rd_low_early, 0);
    for (int n = 0; n < 20000; n++) begin
      if (boot_done) begin
        seen_done = 1;
        break;
      end
      if (pram_we) begin
        if (int'(pram_addr) != wr_cnt || pram_wdata != word_of(1'b1, wr_cnt)) begin
          bad_wr++;
          if (bad_wr == 1)
            $display("FAIL R7 host word %0d actual=%0h expected=%0h",
                     wr_cnt, pram_wdata, word_of(1'b1, wr_cnt));
        end
        if (k != 3 * (wr_cnt + 1)) bad_wtime++;
        wr_cnt++;
      end
      if (ext_rd) rd_bad++;
      if (map_mode != 2'd1 || core_run) mode_bad++;
      prev_we = pram_we;
      v = stalls ? ((n % 3) != 1) : 1'b1;
      host_valid = v && (k < NB);
      host_byte  = host_valid ? host_b(k) : 8'hA5;
      if (!host_valid) host_valid = stalls && (n % 7 == 0) && !host_ready;
      if (host_valid && host_ready) k++;
      @(negedge clk);
    end
    host_valid = 1'b0;
    check(seen_done, "R9 host boot completes", seen_done, 1);
    check(bad_wr == 0, "R7 host words same byte order, no byte taken while not ready", bad_wr, 0);
    check(bad_wtime == 0 && wr_cnt == NW, "R6 host write count and timing", wr_cnt, NW);
    check(k == NB, "R7 host bytes consumed", k, NB);
    check(rd_bad == 0, "R7 no ROM strobe in host mode", rd_bad, 0);
    check(mode_bad == 0, "R8 load map held during host load", mode_bad, 0);
    check_finish(prev_we, "host");
  endtask

  task automatic t_reset_midway();
    do_reset(1'b1);
    repeat (2000) @(negedge clk);
    check(ext_rd && ext_addr != 16'hC000, "R4 load under way before reset", ext_addr, BASE);
    #1 rst_n = 1'b0;
    #0.5;
    check_reset_outputs("async mid-load");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_rom_boot();
    t_host_boot(1'b1);
    t_reset_midway();
    t_host_boot(1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog R9 boot never finished actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule